// File: doc/BRIEF.md
# Periodic Tick Timer with Self-Advancing Comparator

This block is a 64-bit free-running up-counter with a 64-bit comparator. It serves as the periodic system-tick source of a processor subsystem. Software reaches it through a plain 32-bit register port with a select strobe and a write-enable. The port exposes the two counter words, the two compare words, a step value, a control word and an event-status word.

When the comparator is armed and the count has reached the compare value, the block latches a sticky event flag. If interrupts are enabled, that flag drives the interrupt line. If reload is enabled, the compare value moves forward by the step value in the same clock edge. Because each new target is the previous target plus a fixed step, the tick period does not drift, however late software services the event. Software reads the counter upper word, then the lower word, then the upper word again. It accepts the pair only when both upper reads agree.

Top module: `gtick_timer`

## Requirements
- R1: After reset the counter, the compare value, the step value, the control word and the event flag are all zero, `irq_o` is low, and every address reads zero.
- R2: The counter goes up by one on each clock edge while control bit 0 (run) is set. It holds its value while run is clear and neither counter word is being written.
- R3: When the lower counter word wraps from all ones to zero, the upper word goes up by one at that same clock edge.
- R4: A write to address 0 (counter lower word) or address 1 (counter upper word) loads that word only while run is clear. While run is set, such a write is ignored.
- R5: A match occurs in a cycle when control bit 1 (compare enable) is set and the counter is greater than or equal to the compare value. The clock edge that ends a match cycle sets the event flag, which is bit 0 of address 3.
- R6: The event flag stays set until software writes 1 to bit 0 of address 3. Writing 0 to that bit leaves the flag unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the event flag is set and control bit 2 (interrupt enable) is set, and it stays high until the flag is cleared.
- R8: When a match occurs with control bit 3 (reload) set, the compare value increases by the step value (address 6) at the same clock edge.
- R9: A write to address 4 (compare lower word) or address 5 (compare upper word) takes effect at the next clock edge. In that cycle it takes priority over a reload, and the other compare word keeps its value.
- R10: Register map: 0 counter lower, 1 counter upper, 2 control (bits 3:0; all other bits read zero), 3 status (bit 0 is the flag), 4 compare lower, 5 compare upper, 6 step. Address 7 reads zero. All of them read back combinationally.
- R11: While compare enable is clear, no new event is raised. Clearing compare enable and then clearing the flag leaves `irq_o` low for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Tick interrupt, level |

## Verification
Read data and `irq_o` are combinational from registers, so each of them reflects, in the same cycle, the state left by the most recent rising edge. A write, a count step, a flag set and a reload therefore show up on the bus one cycle after the edge that performs them. The bench drives inputs on the falling edge and samples 5 ns later. At that point the behavioural model has already applied the same rising edge, so model and design are compared in the same cycle with no added slack. The write-priority case is checked on the very next cycle, before a later reload can move the compare value again.

// File: rtl/gtick_pkg.sv
package gtick_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NREG   = 1 << ADDR_W;
  localparam int unsigned CTRL_W = 4;

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [2*WORD_W-1:0] dword_t;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_STEP   = 3'd6;

  // control bit positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_CMP  = 1;
  localparam int unsigned C_IRQ  = 2;
  localparam int unsigned C_AINC = 3;

  // replace one half of a double word
  function automatic dword_t set_half(dword_t old, word_t w, logic hi);
    dword_t r;
    r = old;
    if (hi) r[2*WORD_W-1:WORD_W] = w;
    else    r[WORD_W-1:0]        = w;
    return r;
  endfunction

  // unsigned greater-or-equal on the full width
  function automatic logic reached(dword_t c, dword_t t);
    return c >= t;
  endfunction

  // widen a word and add it
  function automatic dword_t bump(dword_t v, word_t step);
    return v + {{WORD_W{1'b0}}, step};
  endfunction

endpackage

// File: rtl/gtick_counter.sv
module gtick_counter
  import gtick_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  word_t  wdata,
  output dword_t cnt,
  output logic   lo_wrap
);

  // lower word about to roll over on this edge
  assign lo_wrap = run && (&cnt[WORD_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= bump(cnt, word_t'(1));
    end else if (wr_lo) begin
      cnt <= set_half(cnt, wdata, 1'b0);
    end else if (wr_hi) begin
      cnt <= set_half(cnt, wdata, 1'b1);
    end
  end

endmodule

// File: rtl/gtick_compare.sv
module gtick_compare
  import gtick_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmp_en,
  input  logic   ai_en,
  input  dword_t cnt,
  input  word_t  step,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  word_t  wdata,
  output dword_t cmp,
  output logic   hit,
  output logic   reload
);

  assign hit    = cmp_en && reached(cnt, cmp);
  // a software write to either half suppresses the self-advance
  assign reload = hit && ai_en && !(wr_lo || wr_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_lo) begin
      cmp <= set_half(cmp, wdata, 1'b0);
    end else if (wr_hi) begin
      cmp <= set_half(cmp, wdata, 1'b1);
    end else if (reload) begin
      cmp <= bump(cmp, step);
    end
  end

endmodule

// File: rtl/gtick_regs.sv
module gtick_regs
  import gtick_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREG-1:0]     wr_strb,
  input  word_t               wdata,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                hit,
  input  dword_t              cnt,
  input  dword_t              cmp,
  output logic [CTRL_W-1:0]   ctrl,
  output word_t               step,
  output logic                flag,
  output logic                irq,
  output word_t               rdata
);

  logic flag_clr;
  assign flag_clr = wr_strb[A_STAT] && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      step <= '0;
    end else begin
      if (wr_strb[A_CTRL]) ctrl <= wdata[CTRL_W-1:0];
      if (wr_strb[A_STEP]) step <= wdata;
    end
  end

  // a new event outranks a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign irq = flag && ctrl[C_IRQ];

  always_comb begin
    case (rd_addr)
      A_CNT_LO: rdata = cnt[WORD_W-1:0];
      A_CNT_HI: rdata = cnt[2*WORD_W-1:WORD_W];
      A_CTRL:   rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl};
      A_STAT:   rdata = {{(WORD_W-1){1'b0}}, flag};
      A_CMP_LO: rdata = cmp[WORD_W-1:0];
      A_CMP_HI: rdata = cmp[2*WORD_W-1:WORD_W];
      A_STEP:   rdata = step;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gtick_timer.sv
module gtick_timer
  import gtick_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);

  logic [NREG-1:0]   wr_strb;
  logic [CTRL_W-1:0] ctrl;
  word_t             step;
  dword_t            cnt;
  dword_t            cmp;
  logic              hit;
  logic              reload;
  logic              flag;
  logic              lo_wrap;

  // one write strobe per word address
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_strb[i] = bus_sel && bus_we && (bus_addr == ADDR_W'(i));
  end

  gtick_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl[C_RUN]),
    .wr_lo   (wr_strb[A_CNT_LO]),
    .wr_hi   (wr_strb[A_CNT_HI]),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .lo_wrap (lo_wrap)
  );

  gtick_compare u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_en (ctrl[C_CMP]),
    .ai_en  (ctrl[C_AINC]),
    .cnt    (cnt),
    .step   (step),
    .wr_lo  (wr_strb[A_CMP_LO]),
    .wr_hi  (wr_strb[A_CMP_HI]),
    .wdata  (bus_wdata),
    .cmp    (cmp),
    .hit    (hit),
    .reload (reload)
  );

  gtick_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_strb (wr_strb),
    .wdata   (bus_wdata),
    .rd_addr (bus_addr),
    .hit     (hit),
    .cnt     (cnt),
    .cmp     (cmp),
    .ctrl    (ctrl),
    .step    (step),
    .flag    (flag),
    .irq     (irq_o),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/gtick_timer_chk.sv
module gtick_timer_chk
  import gtick_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_o,
  input logic [CTRL_W-1:0] ctrl,
  input word_t             step,
  input dword_t            cnt,
  input dword_t            cmp,
  input logic              hit,
  input logic              flag,
  input logic              lo_wrap
);

  logic w_clo, w_chi, w_ctl, w_st, w_mlo, w_mhi;
  assign w_clo = bus_sel && bus_we && bus_addr == A_CNT_LO;
  assign w_chi = bus_sel && bus_we && bus_addr == A_CNT_HI;
  assign w_ctl = bus_sel && bus_we && bus_addr == A_CTRL;
  assign w_st  = bus_sel && bus_we && bus_addr == A_STAT;
  assign w_mlo = bus_sel && bus_we && bus_addr == A_CMP_LO;
  assign w_mhi = bus_sel && bus_we && bus_addr == A_CMP_HI;

  p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[C_RUN] |=> cnt == $past(cnt) + 64'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[C_RUN] && !w_clo && !w_chi) |=> $stable(cnt));

  p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (cnt[63:32] == $past(cnt[63:32]) + 32'd1) && (cnt[31:0] == 32'd0));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[C_RUN] && w_clo) |=> cnt[31:0] == $past(bus_wdata));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(w_st && bus_wdata[0])) |=> flag);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !w_st && !w_ctl) |=> irq_o);

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl[C_AINC] && !w_mlo && !w_mhi) |=> cmp == $past(cmp) + {32'd0, $past(step)});

  p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_mlo |=> (cmp[31:0] == $past(bus_wdata)) && (cmp[63:32] == $past(cmp[63:32])));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[C_CMP] && !flag) |=> !flag);

endmodule

bind gtick_timer gtick_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .ctrl      (ctrl),
  .step      (step),
  .cnt       (cnt),
  .cmp       (cmp),
  .hit       (hit),
  .flag      (flag),
  .lo_wrap   (lo_wrap)
);

// File: tb/gtick_timer_tb_top.sv
module gtick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gtick_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] m_cnt, m_cmp;
  logic [3:0]  m_ctrl;
  logic [31:0] m_inc;
  logic        m_flag;

  always @(posedge clk) begin
    logic [63:0] n_cnt, n_cmp;
    logic        match, wr;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_inc = 0; m_flag = 0;
    end else begin
      wr    = bus_sel && bus_we;
      match = m_ctrl[1] && (m_cnt >= m_cmp);
      n_cnt = m_cnt;
      n_cmp = m_cmp;
      if (m_ctrl[0]) n_cnt = m_cnt + 1;
      else if (wr && bus_addr == 0) n_cnt[31:0]  = bus_wdata;
      else if (wr && bus_addr == 1) n_cnt[63:32] = bus_wdata;
      if (wr && bus_addr == 4)      n_cmp[31:0]  = bus_wdata;
      else if (wr && bus_addr == 5) n_cmp[63:32] = bus_wdata;
      else if (match && m_ctrl[3])  n_cmp = m_cmp + m_inc;
      if (match) m_flag = 1;
      else if (wr && bus_addr == 3 && bus_wdata[0]) m_flag = 0;
      if (wr && bus_addr == 2) m_ctrl = bus_wdata[3:0];
      if (wr && bus_addr == 6) m_inc = bus_wdata;
      m_cnt = n_cnt;
      m_cmp = n_cmp;
    end
  end

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[31:0];
      3'd1: return m_cnt[63:32];
      3'd2: return {28'd0, m_ctrl};
      3'd3: return {31'd0, m_flag};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      3'd6: return m_inc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, 5 ns after the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #5;
      chk("R7 irq", {63'd0, irq_o}, {63'd0, m_flag && m_ctrl[2]});
      if (bus_sel && !bus_we) chk("R10 read", {32'd0, bus_rdata}, {32'd0, mread(bus_addr)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #5;
    chk(tag, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic rd_model(input logic [2:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #5;
    chk(tag, {32'd0, bus_rdata}, {32'd0, mread(a)});
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 300 && !irq_o; k++) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: everything zero after reset
    for (int a = 0; a < 8; a++) rd_exp(3'(a), "R1 reset read", 32'd0);
    chk("R1 irq low", {63'd0, irq_o}, 64'd0);

    // R10: map and read-back widths
    wr(3'd6, 32'hA5A5_0001);
    rd_exp(3'd6, "R10 step readback", 32'hA5A5_0001);
    wr(3'd2, 32'hFFFF_FFF2);
    rd_exp(3'd2, "R10 ctrl bits only", 32'h0000_0002);
    rd_exp(3'd7, "R10 unused addr", 32'd0);
    rd_exp(3'd3, "R5 flag on zero compare", 32'd1);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd1);
    rd_exp(3'd3, "R6 clear by one", 32'd0);

    // R4: load counter while stopped
    wr(3'd0, 32'hFFFF_FFFE);
    wr(3'd1, 32'd5);
    rd_exp(3'd0, "R4 load lower", 32'hFFFF_FFFE);
    rd_exp(3'd1, "R4 load upper", 32'd5);

    // R2 / R3: run across the lower-word wrap
    wr(3'd2, 32'd1);
    repeat (4) @(negedge clk);
    rd_exp(3'd1, "R3 carry into upper", 32'd6);
    rd_model(3'd0, "R2 counting");
    wr(3'd0, 32'h0000_1234);
    rd_model(3'd0, "R4 write ignored while running");

    // R2: hold when stopped
    wr(3'd2, 32'd0);
    rd_model(3'd0, "R2 stopped");
    held = bus_rdata;
    repeat (5) @(negedge clk);
    rd_exp(3'd0, "R2 hold", held);

    // R5 / R7: match raises flag and irq
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd50);
    wr(3'd5, 32'd0);
    wr(3'd2, 32'd7);
    wait_irq();
    chk("R7 irq raised", {63'd0, irq_o}, 64'd1);
    rd_exp(3'd3, "R5 flag set", 32'd1);

    // R6: write 0 ignored; clear during ongoing match loses
    wr(3'd3, 32'd0);
    rd_exp(3'd3, "R6 zero write no effect", 32'd1);
    wr(3'd3, 32'd1);
    rd_exp(3'd3, "R6 set wins over clear", 32'd1);

    // R11: disable compare, then clear
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd1);
    repeat (10) @(negedge clk);
    rd_exp(3'd3, "R11 no new event", 32'd0);
    chk("R11 irq low", {63'd0, irq_o}, 64'd0);

    // R8: self-advancing compare
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd30);
    wr(3'd6, 32'd40);
    wr(3'd2, 32'hF);
    wait_irq();
    rd_exp(3'd4, "R8 compare advanced", 32'd70);
    wr(3'd3, 32'd1);
    repeat (60) @(negedge clk);
    rd_model(3'd4, "R8 second advance");
    rd_model(3'd3, "R8 flag again");

    // R9: software write beats a same-cycle reload
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd100);
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd50);
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd1);
    wr(3'd2, 32'hA);
    repeat (3) @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 3'd4; bus_wdata = 32'd7;
    @(negedge clk);
    bus_we = 0; bus_addr = 3'd4;
    #5;
    chk("R9 write wins", {32'd0, bus_rdata}, 64'd7);
    rd_exp(3'd5, "R9 other half kept", 32'd0);
    wr(3'd5, 32'h0000_0002);
    rd_exp(3'd5, "R9 upper write", 32'd2);

    wr(3'd2, 32'd0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule